// File: doc/BRIEF.md
# Pin Mismatch Interrupt Unit

This unit watches eight general-purpose input pins, grouped as two ports of four, and raises a pending flag for any pin whose synchronized level differs from a reference bit held for that pin. Software reads one status word that shows, for every pin, its reference level and whether it is pending. It acknowledges a pin by writing a new reference level through write-one command fields in that same word. An eight-bit enable word selects which pending pins drive a single registered event line toward the interrupt logic.

Pin index i (0..7) is port0 pins 0..3 for i = 0..3 and port1 pins 0..3 for i = 4..7. A simple register port with one write strobe, a two-bit address and combinational read data gives access to the status word (address 0), the enable word (address 1) and the live synchronized pin levels (address 2). Address 3 reads as zero. The reference level tells the direction of the pending edge: a pending pin with reference 0 went high, and a pending pin with reference 1 went low.

Top module: `gpio_mismatch_irq`

## Requirements
- R1: After reset the reference bits, the pending bits, the enable word and event_o are all 0.
- R2: At every clock edge, the pending bit of pin i takes the value (synchronized level XOR reference bit), unless the same edge acknowledges pin i. The bit therefore drops if the pin returns to its reference level, and it comes back one cycle after an acknowledge that still mismatches.
- R3: A write to address 0 with wdata bit 16+i set and bit 24+i clear sets reference bit i to 1 and clears pending bit i at that edge.
- R4: A write to address 0 with wdata bit 24+i set clears reference bit i to 0 and clears pending bit i. When bits 16+i and 24+i are both set, the clear wins.
- R5: Reading address 0 returns pending bits in [7:0], reference bits in [15:8] and zero in [31:16]. Writing the reference and pending fields has no effect.
- R6: Address 1 is read/write. Bits [7:0] hold the enable word and bits [31:8] read as zero.
- R7: event_o equals the OR over all pins of (pending AND enable), sampled one clock earlier.
- R8: Address 2 returns the synchronized pin levels in [7:0] and zero above them. Writes to address 2 change nothing.
- R9: Each pin passes through two flops. A level applied before edge k shows at address 2 after edge k+1 and affects pending at edge k+2.
- R10: For a pending pin, reference 0 means a low-to-high change and reference 1 means a high-to-low change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Asynchronous pin levels, index = port*4 + pin |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 enable, 2 live levels |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| event_o | output | 1 | Registered OR of enabled pending pins |

## Verification
Two things can fall on the same edge for one pin. A pin can change level while software acknowledges it, and a set and a clear command can be written together. The bench sets both command bits for a pending pin while the pin still differs from the new reference. It expects the reference to be 0, the pending bit to be 0 for exactly one cycle and then to come back. A long stretch of random pin toggles mixed with random writes is compared every cycle against a behavioural model, so that acknowledges landing on the same edge as pin edges are judged by the model's one-edge rule.

// File: rtl/gpio_mismatch_irq.sv
module gpio_mismatch_irq #(
  parameter int PORTS    = 2,
  parameter int PER_PORT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pins_i,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        event_o
);
  localparam int N = PORTS * PER_PORT;

  logic [N-1:0] sync1_q, live_q, ref_q, pend_q, en_q;
  logic [N-1:0] set_cmd, clr_cmd, ack;
  logic         wr_stat, wr_en_reg;

  assign wr_stat   = wr_en && (addr == 2'd0);
  assign wr_en_reg = wr_en && (addr == 2'd1);
  assign clr_cmd   = wr_stat ? wdata[24 +: N] : '0;
  assign set_cmd   = wr_stat ? wdata[16 +: N] : '0;
  assign ack       = set_cmd | clr_cmd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      live_q  <= '0;
    end else begin
      sync1_q <= pins_i[N-1:0];
      live_q  <= sync1_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_q  <= '0;
      pend_q <= '0;
    end else begin
      ref_q  <= (ref_q | set_cmd) & ~clr_cmd;
      pend_q <= (live_q ^ ref_q) & ~ack;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         en_q <= '0;
    else if (wr_en_reg) en_q <= wdata[N-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) event_o <= 1'b0;
    else        event_o <= |(pend_q & en_q);

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: begin
        rdata[N-1:0]   = pend_q;
        rdata[8 +: N]  = ref_q;
      end
      2'd1: rdata[N-1:0] = en_q;
      2'd2: rdata[N-1:0] = live_q;
      default: rdata = '0;
    endcase
  end

  p_pend_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(ack)) == ($past(live_q ^ ref_q) & ~$past(ack)));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(ack)) == '0) &&
    ((ref_q & $past(set_cmd & ~clr_cmd)) == $past(set_cmd & ~clr_cmd)));

  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q & $past(clr_cmd)) == '0);

  p_cmd_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[31:16] == 16'h0));

  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_reg) |-> $stable(en_q));

  p_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    event_o == |($past(pend_q & en_q)));

  p_live_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    live_q == $past(sync1_q));
endmodule

// File: tb/gpio_mismatch_irq_tb_top.sv
module gpio_mismatch_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        event_o;

  int checks = 0;
  int errors = 0;

  bit m_s1[8], m_s2[8], m_ref[8], m_pend[8], m_en[8];
  bit m_ev;

  always #2 clk = ~clk;

  gpio_mismatch_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .event_o(event_o)
  );

  function automatic logic [31:0] m_read(logic [1:0] a);
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) begin
      if (a == 2'd0) begin
        v[i]   = m_pend[i];
        v[8+i] = m_ref[i];
      end else if (a == 2'd1) v[i] = m_en[i];
      else if (a == 2'd2)     v[i] = m_s2[i];
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit n_ev = 1'b0;
    for (int i = 0; i < 8; i++)
      if (m_pend[i] && m_en[i]) n_ev = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bit st, cl;
      st = wr_en && addr == 2'd0 && wdata[16+i];
      cl = wr_en && addr == 2'd0 && wdata[24+i];
      m_pend[i] = (st || cl) ? 1'b0 : (m_s2[i] != m_ref[i]);
      if (cl)      m_ref[i] = 1'b0;
      else if (st) m_ref[i] = 1'b1;
      if (wr_en && addr == 2'd1) m_en[i] = wdata[i];
      m_s2[i] = m_s1[i];
      m_s1[i] = pins[i];
    end
    m_ev = n_ev;
  endtask

  task automatic step(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check("R7", {31'b0, event_o}, {31'b0, m_ev});
    check(tag, rdata, m_read(addr));
  endtask

  task automatic rd(logic [1:0] a, string tag);
    addr = a;
    step(tag);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
    addr = a; wdata = d; wr_en = 1'b1;
    step(tag);
    wr_en = 1'b0; wdata = '0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", rdata, 32'h0);
    check("R1", {31'b0, event_o}, 32'h0);
    rd(2'd1, "R1");
    rd(2'd0, "R1");

    pins[0] = 1'b1;
    rd(2'd2, "R9");
    rd(2'd2, "R9");
    rd(2'd0, "R9");
    rd(2'd0, "R10");
    rd(2'd2, "R8");

    wr(2'd1, 32'hFFFF_FF01, "R6");
    rd(2'd1, "R6");
    rd(2'd0, "R7");
    rd(2'd0, "R7");

    wr(2'd0, 32'h0000_FF01 | (32'h1 << 16), "R3");
    rd(2'd0, "R3");
    rd(2'd0, "R5");

    pins[0] = 1'b0;
    repeat (3) rd(2'd0, "R10");
    wr(2'd0, 32'h1 << 24, "R4");
    rd(2'd0, "R4");

    pins[5] = 1'b1;
    repeat (3) rd(2'd0, "R2");
    wr(2'd0, (32'h1 << 21) | (32'h1 << 29), "R4");
    rd(2'd0, "R4");
    rd(2'd0, "R2");

    pins[5] = 1'b0;
    repeat (3) rd(2'd0, "R2");

    pins[3] = 1'b1;
    repeat (3) rd(2'd2, "R8");
    wr(2'd2, 32'h0000_0000, "R8");
    rd(2'd2, "R8");
    wr(2'd2, 32'hFFFF_FFFF, "R8");
    rd(2'd2, "R8");

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(3) == 0) pins = 8'($urandom);
      if ($urandom_range(4) == 0)
        wr(2'($urandom), $urandom, "R2");
      else
        rd(2'($urandom), "R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule